// File: doc/BRIEF.md
# Peripheral Interrupt Pending and Vector Unit

This block gathers sixteen peripheral interrupt sources into one request line for the CPU. Each source holds a sticky pending flag. A single-cycle request pulse sets the flag, and it stays set until the interrupt is serviced or software rewrites it. A mask input selects which pending sources may interrupt. Among the sources that are both pending and unmasked, the lowest-numbered one is chosen. Its vector address is formed as a fixed base plus four bytes per source number.

Once the request line is high, the presented vector is frozen until the CPU acknowledges it. A higher-priority source that arrives in the meantime therefore cannot change the address under the CPU. The acknowledge strobe clears only the pending flag of the presented source.

Software reads the whole pending word through the register bus. A write loads the word directly, so writing a 1 raises an interrupt exactly as a hardware pulse would, and writing a 0 withdraws one.

Top module: `periph_irq_vector_unit`

## Requirements
- R1: A 1 on `src_req[n]` in a cycle sets pending bit n at the next clock edge, and the bit stays set on later cycles without further pulses.
- R2: After reset the pending word is 0x0000, `irq` is 0 and `vec_addr` is 0xFF20C0.
- R3: `vec_ack` while `irq` is 1 and `bus_wr` is 0 clears exactly the pending bit of the presented source at the next edge; all other bits are unchanged.
- R4: If a hardware request and the acknowledge clear hit the same bit in the same cycle, the bit stays set.
- R5: Among bits that are pending and unmasked (`src_mask[n]`=1), the lowest index n is presented.
- R6: The vector for source n is 0xFF20C0 + 4·n, for n = 0 to 15.
- R7: `bus_wr`=1 loads `bus_wdata` into the pending word: bit=1 sets, bit=0 clears. A same-cycle hardware request still sets its bit, and `vec_ack` clears nothing in that cycle.
- R8: `irq` is 1 exactly when some pending bit has its mask bit set. A masked pending bit stays pending but raises no request.
- R9: While `irq` stays 1, with no acknowledge, no bus write and no mask change, `vec_addr` does not change, even if a lower-numbered source becomes pending.
- R10: `bus_rdata` always shows the current pending word, bit n for source n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 16 | Per-source request pulses |
| src_mask | input | 16 | Per-source enable mask (1 = may interrupt) |
| bus_wr | input | 1 | Register write strobe for the pending word |
| bus_wdata | input | 16 | Write data for the pending word |
| bus_rdata | output | 16 | Current pending word |
| vec_ack | input | 1 | CPU acknowledge of the presented vector |
| irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 24 | Vector address of the presented source |

## Verification
Several properties are checked on every cycle. A request pulse must always leave its bit set one cycle later, even against an acknowledge or a write. An acknowledge must remove exactly one pending bit. The vector must stay on the four-byte grid inside the sixteen-entry window and hold steady while an unacknowledged request waits. The priority pick must grant at most one source, and a fully masked pending word must never raise the request line. The bench scenarios cover the rest: the exact priority order, the vector value for each source, software set and clear through writes, and the reset state.

// File: rtl/pvu_pkg.sv
package pvu_pkg;
  // Vector address of a source: base plus index scaled by the stride.
  function automatic logic [23:0] vec_of(input logic [23:0] base,
                                         input int unsigned idx,
                                         input int unsigned shift);
    logic [23:0] off;
    off = 24'(idx) << shift;
    return base + off;
  endfunction
endpackage

// File: rtl/pvu_pend_bank.sv
module pvu_pend_bank #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hw_set,
  input  logic             sw_wr,
  input  logic [N_SRC-1:0] sw_data,
  input  logic [N_SRC-1:0] ack_clr,
  output logic [N_SRC-1:0] pend
);
  logic [N_SRC-1:0] kept;
  logic [N_SRC-1:0] pend_nxt;

  // A write replaces the word; otherwise acknowledge clears; set always wins.
  always_comb begin
    kept     = sw_wr ? sw_data : (pend & ~ack_clr);
    pend_nxt = kept | hw_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end
endmodule

// File: rtl/pvu_prio_pick.sv
module pvu_prio_pick #(
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_SRC-1:0] act,
  output logic [N_SRC-1:0] grant,
  output logic [IDX_W-1:0] win_idx,
  output logic             any
);
  logic [N_SRC:0] blocked;
  assign blocked[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_chain
      assign grant[g]     = act[g] & ~blocked[g];
      assign blocked[g+1] = blocked[g] | act[g];
    end
  endgenerate

  assign any = blocked[N_SRC];

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++)
      if (grant[i]) win_idx = win_idx | IDX_W'(i);
  end
endmodule

// File: rtl/pvu_vec_hold.sv
module pvu_vec_hold #(
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] act,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             any,
  input  logic             ack,
  output logic [IDX_W-1:0] cur_idx
);
  logic             held_vld;
  logic [IDX_W-1:0] held_idx;
  logic             held_live;

  // A held choice is kept only while its source is still active.
  assign held_live = held_vld && act[held_idx];
  assign cur_idx   = held_live ? held_idx : win_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_vld <= 1'b0;
      held_idx <= '0;
    end else begin
      held_vld <= any && !ack;
      held_idx <= cur_idx;
    end
  end
endmodule

// File: rtl/periph_irq_vector_unit.sv
module periph_irq_vector_unit #(
  parameter int          N_SRC     = 16,
  parameter logic [23:0] VEC_BASE  = 24'hFF20C0,
  parameter int          VEC_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_mask,
  input  logic             bus_wr,
  input  logic [N_SRC-1:0] bus_wdata,
  output logic [N_SRC-1:0] bus_rdata,
  input  logic             vec_ack,
  output logic             irq,
  output logic [23:0]      vec_addr
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] act;
  logic [N_SRC-1:0] grant_vec;
  logic [N_SRC-1:0] ack_clr;
  logic [IDX_W-1:0] win_idx;
  logic [IDX_W-1:0] cur_idx;
  logic             any_act;
  logic             ack_take;

  assign act      = pend & src_mask;
  assign ack_take = vec_ack && any_act && !bus_wr;
  assign ack_clr  = ack_take ? (N_SRC'(1) << cur_idx) : '0;

  pvu_pend_bank #(.N_SRC(N_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .hw_set(src_req), .sw_wr(bus_wr),
    .sw_data(bus_wdata), .ack_clr(ack_clr), .pend(pend)
  );

  pvu_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
    .act(act), .grant(grant_vec), .win_idx(win_idx), .any(any_act)
  );

  pvu_vec_hold #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .act(act), .win_idx(win_idx),
    .any(any_act), .ack(vec_ack), .cur_idx(cur_idx)
  );

  assign irq       = any_act;
  assign bus_rdata = pend;
  assign vec_addr  = pvu_pkg::vec_of(VEC_BASE, int'(cur_idx), VEC_SHIFT);
endmodule

// File: rtl/pvu_checker.sv
module pvu_checker #(
  parameter int          N_SRC     = 16,
  parameter logic [23:0] VEC_BASE  = 24'hFF20C0,
  parameter int          VEC_SHIFT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_req,
  input logic [N_SRC-1:0] src_mask,
  input logic             bus_wr,
  input logic [N_SRC-1:0] bus_rdata,
  input logic             vec_ack,
  input logic             irq,
  input logic [23:0]      vec_addr,
  input logic [N_SRC-1:0] grant_vec
);
  localparam logic [23:0] VEC_SPAN  = 24'((N_SRC - 1) << VEC_SHIFT);
  localparam logic [23:0] GRID_MASK = 24'((1 << VEC_SHIFT) - 1);

  logic [23:0] vec_off;
  assign vec_off = vec_addr - VEC_BASE;

  // R1 and R4: a request pulse always leaves its bit set, whatever else happens
  assert_req_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req != '0) |=> ((bus_rdata & $past(src_req)) == $past(src_req)));

  // R3: a plain acknowledge removes exactly one pending bit
  assert_ack_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && irq && !bus_wr && src_req == '0)
      |=> ($countones(bus_rdata) == $countones($past(bus_rdata)) - 1));

  // R6: the vector lies on the stride grid inside the source window
  assert_vec_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_off & GRID_MASK) == '0) && (vec_off <= VEC_SPAN));

  // R9: an unacknowledged request keeps its vector
  assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !vec_ack && !bus_wr) |=> ($stable(vec_addr) || !$stable(src_mask)));

  // R5: the priority pick grants at most one source
  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R8: fully masked pending bits never raise the request
  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & src_mask) == '0) |-> !irq);
endmodule

bind periph_irq_vector_unit pvu_checker #(
  .N_SRC(N_SRC), .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_mask(src_mask),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .vec_ack(vec_ack), .irq(irq),
  .vec_addr(vec_addr), .grant_vec(grant_vec)
);

// File: tb/periph_irq_vector_unit_test.sv
module periph_irq_vector_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_req = '0, src_mask = '0, bus_wdata = '0;
  logic        bus_wr = 1'b0, vec_ack = 1'b0;
  logic [15:0] bus_rdata;
  logic        irq;
  logic [23:0] vec_addr;

  periph_irq_vector_unit uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_mask(src_mask),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vec_ack(vec_ack), .irq(irq), .vec_addr(vec_addr)
  );

  always #10 clk = ~clk;   // 50 MHz, 20-unit period

  typedef struct {
    logic [15:0] pend;
    logic        irq;
    logic [23:0] vec;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int applied = 0;
  int miscompares = 0;

  // Bench model state
  logic [15:0] m_pend = '0;
  logic        m_hv = 1'b0;
  int          m_hi = 0;

  function automatic int lowest(input logic [15:0] a);
    int r = 0;
    for (int i = 15; i >= 0; i--) if (a[i]) r = i;
    return r;
  endfunction

  function automatic int pick(input logic [15:0] a, input logic hv, input int hi);
    if (hv && a[hi]) return hi;
    return lowest(a);
  endfunction

  task automatic compare(input exp_t e);
    applied++;
    if (bus_rdata !== e.pend || irq !== e.irq || vec_addr !== e.vec) begin
      miscompares++;
      $display("FAIL %s: pend=%h irq=%b vec=%h expected pend=%h irq=%b vec=%h",
               e.tag, bus_rdata, irq, vec_addr, e.pend, e.irq, e.vec);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic apply(input logic [15:0] req, input logic [15:0] msk,
                       input logic wr, input logic [15:0] wd,
                       input logic ack, input string tag);
    logic [15:0] a, nxt, clr;
    int          cur;
    logic        req_on;
    exp_t        e;
    @(negedge clk);
    src_req = req; src_mask = msk; bus_wr = wr; bus_wdata = wd; vec_ack = ack;
    a      = m_pend & msk;
    req_on = (a != 0);
    cur    = pick(a, m_hv, m_hi);
    clr    = (ack && req_on && !wr) ? (16'h1 << cur) : 16'h0;
    nxt    = (wr ? wd : (m_pend & ~clr)) | req;
    m_hv   = req_on && !ack;
    m_hi   = cur;
    m_pend = nxt;
    @(posedge clk);
    #1;
    a      = m_pend & msk;
    e.pend = m_pend;
    e.irq  = (a != 0);
    e.vec  = 24'hFF20C0 + 24'(4 * pick(a, m_hv, m_hi));
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops and compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    #2;
    // R2: reset state
    r.pend = 16'h0; r.irq = 1'b0; r.vec = 24'hFF20C0; r.tag = "R2 reset";
    compare(r);
    @(negedge clk); rst_n = 1'b1;

    // R1: a pulse sets a sticky bit; R8: masked bit raises nothing
    apply(16'h0020, 16'h0000, 0, 0, 0, "R1 pulse sets bit 5");
    apply(16'h0000, 16'h0000, 0, 0, 0, "R1 bit 5 sticky, R8 masked quiet");
    // R8, R6, R10: unmasking raises irq, vector 0xFF20D4
    apply(16'h0000, 16'hFFFF, 0, 0, 0, "R8 unmask raises irq");
    // R7: software clear by writing zero
    apply(16'h0000, 16'hFFFF, 1, 16'h0000, 0, "R7 write clears all");
    // R5: bits 9 and 3 together, lowest wins
    apply(16'h0208, 16'hFFFF, 0, 0, 0, "R5 lowest of 9 and 3");
    apply(16'h0000, 16'hFFFF, 0, 0, 0, "R5 holds 3");
    // R9: lower source 1 arrives, vector stays on 3
    apply(16'h0002, 16'hFFFF, 0, 0, 0, "R9 vector held against source 1");
    apply(16'h0000, 16'hFFFF, 0, 0, 0, "R9 still held");
    // R3: acknowledge clears only bit 3
    apply(16'h0000, 16'hFFFF, 0, 0, 1, "R3 ack clears presented bit");
    // R4: ack on source 1 with a new request on source 1
    apply(16'h0002, 16'hFFFF, 0, 0, 1, "R4 set beats ack clear");
    apply(16'h0000, 16'hFFFF, 0, 0, 1, "R3 ack clears bit 1");
    // R5: mask hides low bit, higher one presented
    apply(16'h0001, 16'hFFFE, 0, 0, 0, "R5 masked bit 0 skipped");
    // R7: software set of bit 15 behaves like a request
    apply(16'h0000, 16'hFFFF, 1, 16'h8000, 0, "R7 write sets bit 15");
    apply(16'h0000, 16'h8000, 0, 0, 0, "R7 bit 15 presented");
    // R7: write with same-cycle request and ignored ack
    apply(16'h0004, 16'hFFFF, 1, 16'h0000, 1, "R7 write, req kept, ack ignored");
    apply(16'h0000, 16'hFFFF, 0, 0, 0, "R7 after write");
    // R6: vector for every source
    for (int n = 0; n < 16; n++)
      apply(16'h0000, 16'hFFFF, 1, 16'h1 << n, 0, "R6 vector per source");
    // R8: mask everything
    apply(16'h0000, 16'h0000, 0, 0, 0, "R8 all masked");
    apply(16'h0000, 16'h0000, 1, 16'h0000, 0, "R10 cleared word");

    repeat (3) @(posedge clk);
    #5;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule